// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a synchronous on-chip requester read and write an external 128K by 8 asynchronous static RAM. The requester presents an address, write data and a read/write flag with a one-cycle request strobe. The controller sequences the memory pins and answers with a one-cycle ready pulse. After a read, the captured byte appears on a read-data output. The memory side carries 17 address lines and a split data bus: an output value, an output-enable for the pad driver and an input value. It also drives a select pair of opposite polarity, an active-low output enable and an active-low write enable.

Every wait is counted in clock cycles derived from parameters. These are the clock period in nanoseconds and the memory's nanosecond minimums. Each minimum is converted by ceiling division, and a nonzero minimum is never rounded below one cycle. Writes are controlled by the write enable, and output enable stays high for the whole write. The pad driver is on only while write enable is low. Between accesses the select pair is parked inactive, so the memory sits in standby with its pins floating.

The state machine has five states. ST_IDLE (deselected) accepts a request. From ST_IDLE a write goes to ST_WPULSE (write enable low, driver on), then to ST_WREC (write enable high, still selected), then back to ST_IDLE. From ST_IDLE a read goes to ST_RACC (output enable low), then to ST_TURN (deselected bus turnaround), then back to ST_IDLE. Each timed state ends when its wait counter reaches its last cycle.

Top module: `asram_ctrl`

## Requirements
- R1: A request strobe is taken only in ST_IDLE. A strobe raised while a write or read is in progress, or during the turnaround after a read, causes no memory access and no ready pulse.
- R2: Out of reset and whenever no access is in progress, mem_sel_n=1, mem_sel=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0 and req_ready=0.
- R3: A write holds mem_we_n low for WP cycles, the largest converted minimum of pulse width, address-to-end and data setup (2 at defaults). mem_addr and mem_dq_out are constant and the memory is selected throughout. One recovery cycle with mem_we_n high and the memory still selected follows (recovery is at least 1 and covers the write cycle time).
- R4: mem_oe_n is high in every cycle where mem_we_n is low. mem_dq_oe is high only while mem_we_n is low, so the controller never drives while the memory may drive.
- R5: A read selects the memory with mem_oe_n low and mem_we_n high for RD cycles, the largest converted minimum of address access, output-enable access and read cycle time (3 at defaults). req_rdata takes mem_dq_in on the edge that ends the last of those cycles.
- R6: After a read the memory is deselected with mem_oe_n high for at least one turnaround cycle before any following access. The first cycle of mem_dq_oe high is always preceded by a cycle with mem_oe_n high.
- R7: req_ready is high for exactly one cycle per accepted request. At defaults it is high in the fourth cycle counted from the cycle after the accepting edge, for both reads and writes.
- R8: req_rdata keeps its value until the next read completes; writes do not change it.
- R9: A read returns the byte most recently written to that address, across the full address range (0 to 17'h1FFFF) and data patterns 8'h00, 8'h5A, 8'hA5 and 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Last read byte |
| mem_addr | output | 17 | Memory address lines |
| mem_dq_out | output | 8 | Value driven onto the memory data bus |
| mem_dq_oe | output | 1 | Enables the data-bus pad driver |
| mem_dq_in | input | 8 | Value seen on the memory data bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |

## Verification
The controller is driven with several patterns, and each one separates a different fault. Isolated writes followed by reads at the address extremes and with complementary data patterns expose address or data bit errors. A read of a never-written address shows whether an access reached the wrong location. A write placed directly after a read separates correct turnaround from a driver turned on while output enable is still low. Strobes placed inside a write, inside a read and in the post-read turnaround cycle tell a busy-state filter apart from one that lets a second access slip in. A write that follows a read shows whether read data is wrongly overwritten.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WPULSE = 3'd1,
        ST_WREC   = 3'd2,
        ST_RACC   = 3'd3,
        ST_TURN   = 3'd4
    } ctl_state_t;

    // nanoseconds to whole clock cycles, rounded up; zero stays zero
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/asram_pin_drv.sv
module asram_pin_drv
    import asram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctl_state_t st_nxt,
    output logic       sel_n,
    output logic       sel,
    output logic       oe_n,
    output logic       we_n,
    output logic       dq_oe
);
    // pins are registered from the next state so they change cleanly on the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_n <= 1'b1;
            sel   <= 1'b0;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            unique case (st_nxt)
                ST_WPULSE: begin
                    sel_n <= 1'b0; sel <= 1'b1; oe_n <= 1'b1; we_n <= 1'b0; dq_oe <= 1'b1;
                end
                ST_WREC: begin
                    sel_n <= 1'b0; sel <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0;
                end
                ST_RACC: begin
                    sel_n <= 1'b0; sel <= 1'b1; oe_n <= 1'b0; we_n <= 1'b1; dq_oe <= 1'b0;
                end
                default: begin
                    sel_n <= 1'b1; sel <= 1'b0; oe_n <= 1'b1; we_n <= 1'b1; dq_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 4,
    parameter int T_WC   = 10,
    parameter int T_WP   = 8,
    parameter int T_AW   = 8,
    parameter int T_DW   = 5,
    parameter int T_AH   = 0,
    parameter int T_DH   = 0,
    parameter int T_RC   = 10,
    parameter int T_AA   = 10,
    parameter int T_OE   = 6,
    parameter int T_HZ   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int WP_CYC  = imax(1, imax(ns_to_cyc(T_WP, CLK_NS),
                                 imax(ns_to_cyc(T_AW, CLK_NS), ns_to_cyc(T_DW, CLK_NS))));
    localparam int REC_CYC = imax(1, imax(ns_to_cyc(T_AH, CLK_NS),
                                 imax(ns_to_cyc(T_DH, CLK_NS), ns_to_cyc(T_WC, CLK_NS) - WP_CYC)));
    localparam int RD_CYC  = imax(1, imax(ns_to_cyc(T_AA, CLK_NS),
                                 imax(ns_to_cyc(T_OE, CLK_NS), ns_to_cyc(T_RC, CLK_NS))));
    localparam int TA_CYC  = imax(1, ns_to_cyc(T_HZ, CLK_NS));
    localparam int MAX_CYC = imax(imax(WP_CYC, REC_CYC), imax(RD_CYC, TA_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_t        st_q, st_nxt;
    logic              cnt_load, cnt_last;
    logic [CNT_W-1:0]  cnt_val;
    logic              accept, done, capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              ready_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // transitions and wait loads
    always_comb begin
        st_nxt   = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        done     = 1'b0;
        capture  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    if (req_write) begin
                        st_nxt  = ST_WPULSE;
                        cnt_val = CNT_W'(WP_CYC);
                    end else begin
                        st_nxt  = ST_RACC;
                        cnt_val = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_WPULSE: begin
                if (cnt_last) begin
                    st_nxt   = ST_WREC;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(REC_CYC);
                end
            end
            ST_WREC: begin
                if (cnt_last) begin
                    st_nxt = ST_IDLE;
                    done   = 1'b1;
                end
            end
            ST_RACC: begin
                if (cnt_last) begin
                    st_nxt   = ST_TURN;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(TA_CYC);
                    done     = 1'b1;
                    capture  = 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt_last) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // request capture and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= done;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    asram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    asram_pin_drv u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .st_nxt (st_nxt),
        .sel_n  (mem_sel_n),
        .sel    (mem_sel),
        .oe_n   (mem_oe_n),
        .we_n   (mem_we_n),
        .dq_oe  (mem_dq_oe)
    );

    assign req_ready  = ready_q;
    assign req_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 4,
    parameter int T_WP   = 8,
    parameter int T_AW   = 8,
    parameter int T_DW   = 5,
    parameter int T_RC   = 10,
    parameter int T_AA   = 10,
    parameter int T_OE   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_oe_n,
    input logic              mem_we_n
);
    localparam int WP_EXP = imax(1, imax(ns_to_cyc(T_WP, CLK_NS),
                                imax(ns_to_cyc(T_AW, CLK_NS), ns_to_cyc(T_DW, CLK_NS))));
    localparam int RD_EXP = imax(1, imax(ns_to_cyc(T_AA, CLK_NS),
                                imax(ns_to_cyc(T_OE, CLK_NS), ns_to_cyc(T_RC, CLK_NS))));

    logic [7:0] we_low_cnt, oe_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= mem_we_n ? 8'd0 : ((we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1);
            oe_low_cnt <= mem_oe_n ? 8'd0 : ((oe_low_cnt == 8'hFF) ? oe_low_cnt : oe_low_cnt + 8'd1);
        end
    end

    p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe && !mem_sel));

    p_wpulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == 8'(WP_EXP)));

    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out) && !mem_sel_n && mem_sel));

    p_oe_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_drv_in_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    p_read_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_low_cnt == 8'(RD_EXP)));

    p_turn_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> mem_sel_n);

    p_turn_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> !mem_dq_oe);

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CLK_NS (CLK_NS),
    .T_WP   (T_WP),
    .T_AW   (T_AW),
    .T_DW   (T_DW),
    .T_RC   (T_RC),
    .T_AA   (T_AA),
    .T_OE   (T_OE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int WP  = 2;   // R3 at defaults
    localparam int RD  = 3;   // R5 at defaults
    localparam int LAT = 4;   // R7 at defaults

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, mem_sel_n, mem_sel, mem_oe_n, mem_we_n;

    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model
    logic [7:0] mem_arr [int];
    logic [7:0] ref_arr [int];
    logic model_drv;
    assign model_drv = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;

    initial mem_dq_in = 8'h00;
    always @(posedge clk)
        if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_oe)
            mem_arr[int'(mem_addr)] = mem_dq_out;
    always @(negedge clk) begin
        if (model_drv)
            mem_dq_in <= mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_dq_in <= 8'h00;
    end

    // scoreboard
    typedef struct { bit is_rd; logic [16:0] a; logic [7:0] d; } item_t;
    item_t exp_q[$];

    always @(negedge clk) begin
        if (rst_n && req_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1/R7", "ready with no accepted request", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (it.is_rd) chk(req_rdata == it.d, "R5/R9", "read data", req_rdata, it.d);
                else          chk(1'b1, "R7", "write completion", 1, 1);
            end
        end
    end

    // pin monitor
    int we_run = 0, oe_run = 0;
    logic [16:0] w_a;
    logic [7:0]  w_d;
    logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                if (we_run == 0) begin w_a = mem_addr; w_d = mem_dq_out; end
                else chk(mem_addr == w_a && mem_dq_out == w_d, "R3", "addr/data held in pulse",
                         mem_addr, w_a);
                we_run++;
                chk(mem_oe_n == 1'b1, "R4", "oe_n high while writing", mem_oe_n, 1);
                chk(!mem_sel_n && mem_sel, "R3", "selected in pulse", mem_sel, 1);
            end else if (we_run > 0) begin
                chk(we_run == WP, "R3", "write pulse length", we_run, WP);
                chk(!mem_sel_n && mem_sel && !mem_dq_oe, "R3", "recovery cycle", mem_sel_n, 0);
                we_run = 0;
            end
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin
                chk(oe_run == RD, "R5", "read strobe length", oe_run, RD);
                oe_run = 0;
            end
            if (mem_dq_oe) begin
                chk(!model_drv && !mem_we_n, "R4", "driver only in pulse, no contention",
                    model_drv, 0);
                if (!prev_dq_oe)
                    chk(prev_oe_n == 1'b1, "R6", "oe_n high before driver on", prev_oe_n, 1);
            end
            prev_oe_n  = mem_oe_n;
            prev_dq_oe = mem_dq_oe;
        end
    end

    task automatic check_standby(input string req);
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe, req,
            "standby pins", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!req_ready, req, "no ready after ignored strobe", req_ready, 0);
        end
    endtask

    // driver: stray = strobe during the access, tstray = strobe in the turnaround cycle
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d,
                         input bit stray, input bit tstray);
        item_t it;
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        it.is_rd = !wr; it.a = a;
        if (wr) begin ref_arr[int'(a)] = d; it.d = d; end
        else it.d = ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : dflt(a);
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (stray) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 17'h0F0F0; req_wdata = ~d;
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end
        while (!req_ready && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == LAT, "R7", "request to ready latency", lat, LAT);
        if (!wr) begin
            chk(mem_sel_n && mem_oe_n, "R6", "deselected in turnaround", mem_sel_n, 1);
            if (tstray) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = ~it.d;
                @(negedge clk);
                req_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_ready, "R2", "ready low in reset", req_ready, 0);
        check_standby("R2");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_standby("R2");

        issue(1, 17'h00000, 8'h00, 0, 0);
        issue(1, 17'h1FFFF, 8'hFF, 0, 0);
        issue(1, 17'h12345, 8'hA5, 0, 0);
        check_standby("R2");
        issue(0, 17'h12345, 8'h00, 0, 0);  // R9
        issue(0, 17'h00000, 8'h00, 0, 0);
        issue(0, 17'h1FFFF, 8'h00, 0, 0);
        issue(0, 17'h00777, 8'h00, 0, 0);  // never written
        // R8: a write does not disturb read data
        issue(1, 17'h00002, 8'h11, 0, 0);
        chk(req_rdata == dflt(17'h00777), "R8", "rdata held across write", req_rdata,
            dflt(17'h00777));
        // R6: write directly after read
        issue(0, 17'h00000, 8'h00, 0, 0);
        issue(1, 17'h00010, 8'h5A, 0, 0);
        // R1: strobe inside a write, inside a read, and in turnaround
        issue(1, 17'h0ABCD, 8'h3C, 1, 0);
        quiet(6, "R1");
        issue(0, 17'h0ABCD ^ 17'h0F0F0, 8'h00, 0, 0);
        issue(0, 17'h12345, 8'h00, 1, 0);
        quiet(6, "R1");
        issue(0, 17'h12345 ^ 17'h0F0F0, 8'h00, 0, 1);
        quiet(6, "R1");
        issue(0, 17'h12345 ^ 17'h0F0F0, 8'h00, 0, 0);
        check_standby("R2");
        // sweep
        for (int i = 0; i < 16; i++) issue(1, 17'(i * 17'h01111), 8'(i * 17 + 3), 0, 0);
        for (int i = 0; i < 16; i++) issue(0, 17'(i * 17'h01111), 8'h00, 0, 0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "all requests answered", exp_q.size(), 0);
        check_standby("R2");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule